// File: doc/BRIEF.md
# Attributed Address Window Decoder

This block sorts a 32-bit bus address into one of a small set of programmable address windows. A memory-to-memory engine uses it to decide where each access goes: to one of several DRAM chip selects, or to on-chip SRAM. Each window has a base, a size mask and an 8-bit target attribute. One shared control word enables the windows and gives each one a two-bit access right.

Software programs the block through a simple register port. Each write selects one register, and a combinational read port returns any register. A lookup uses only the upper half of the address. The result appears in the same cycle: a hit or miss flag, the index of the winning window, that window's target attribute, and a protection error when the window does not grant the requested direction. The block also holds an address-override word. Software can write it, read it back and clear it, and it has no effect on lookups.

The design supports up to eight windows. The default is five: four DRAM chip selects and one SRAM window.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, every register reads back as zero, so every window is disabled and every lookup misses.
- R2: A write lands on the next rising clock edge. Read-back then returns the stored value: all 32 bits for the control word and for the override word; bits [31:8] for a base register, with bits [7:0] reading 0; bits [31:16] for a size register, with bits [15:0] reading 0.
- R3: Window i matches when (addr[31:16] & ~mask_i) equals (base_i[31:16] & ~mask_i). A mask of 0x03FF gives a 64 MB window and a mask of 0x0FFF gives a 256 MB window.
- R4: Window i takes part in matching only while bit i of the control word is 1.
- R5: When several enabled windows match, the lowest-numbered one wins and its index is driven on `lk_win`.
- R6: When no enabled window matches, `lk_miss` is 1 and `lk_hit` is 0. In that case `lk_win`, `lk_attr` and `lk_prot_err` are all 0.
- R7: On a hit, `lk_attr` carries bits [15:8] of the winning window's base register.
- R8: Window i's access field is control bits [17+2i:16+2i]. The low bit of the field grants read and the high bit grants write. `lk_prot_err` is 1 when a hit lands on a window that lacks the right for the direction given by `lk_write`.
- R9: Register selects are fixed as follows: 0 is the control word, 1 is the override word, 2+2i is the base of window i and 3+2i is the size of window i. A write to any other select changes no register, and a read of any other select returns 0.
- R10: The override word has no effect on any lookup output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select for a write |
| wr_data | input | 32 | Write data |
| rd_sel | input | SEL_W | Register select for a read |
| rd_data | output | 32 | Read data (combinational) |
| lk_addr | input | 32 | Address to look up |
| lk_write | input | 1 | 1 for a write lookup, 0 for a read lookup |
| lk_hit | output | 1 | An enabled window matched |
| lk_miss | output | 1 | No enabled window matched |
| lk_win | output | IDX_W | Index of the winning window |
| lk_attr | output | 8 | Target attribute of the winning window |
| lk_prot_err | output | 1 | The hit lacks the requested access right |

## Verification
The hardest case to reach from the ports is several enabled windows matching at once while they carry different rights. In that case both the priority order and the protection check of the winning window must be visible. The bench reaches it by loading every DRAM window with base 0 and a 256 MB mask. It then sweeps addresses under several enable patterns and access patterns, so that a lower window's enable bit decides which attribute and which error appear. Expected results come from a bench model built from the register values it wrote.

// File: rtl/awd_pkg.sv
package awd_pkg;
    // Register select map (fixed; the read and write ports decode it)
    localparam int SEL_CTRL  = 0;
    localparam int SEL_OVRD  = 1;
    localparam int SEL_WIN0  = 2;

    // Position of the per-window access fields inside the control word
    localparam int ACC_LSB   = 16;

    // Bit meaning inside one access field
    localparam int ACC_RD    = 0;
    localparam int ACC_WR    = 1;

    typedef logic [1:0]  acc_t;
    typedef logic [15:0] hi_t;
    typedef logic [7:0]  attr_t;
endpackage

// File: rtl/awd_regfile.sv
// awd_regfile: holds the control word, the override word and, for each
// window, a base (upper half plus an attribute byte) and a size mask.
// Assumes one write per cycle, a synchronous active-low reset, and
// NUM_WIN <= 8 so that every access field fits in the control word.
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int SEL_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [31:0]             wr_data,
    input  logic [SEL_W-1:0]        rd_sel,
    output logic [31:0]             rd_data,
    output logic [31:0]             ctrl_q,
    output logic [31:0]             ovrd_q,
    output hi_t   [NUM_WIN-1:0]     base_q,
    output attr_t [NUM_WIN-1:0]     attr_q,
    output hi_t   [NUM_WIN-1:0]     mask_q
);
    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_sel == SEL_W'(SEL_CTRL))
            ctrl_q <= wr_data;
    end

    // Override word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovrd_q <= '0;
        else if (wr_en && wr_sel == SEL_W'(SEL_OVRD))
            ovrd_q <= wr_data;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int BASE_SEL = SEL_WIN0 + 2 * i;
        localparam int SIZE_SEL = SEL_WIN0 + 2 * i + 1;

        // Base and attribute of window i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                attr_q[i] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(BASE_SEL)) begin
                base_q[i] <= wr_data[31:16];
                attr_q[i] <= wr_data[15:8];
            end
        end

        // Size mask of window i
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[i] <= '0;
            else if (wr_en && wr_sel == SEL_W'(SIZE_SEL))
                mask_q[i] <= wr_data[31:16];
        end
    end

    // Read mux; unmapped selects return zero
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_W'(SEL_CTRL))
            rd_data = ctrl_q;
        else if (rd_sel == SEL_W'(SEL_OVRD))
            rd_data = ovrd_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rd_sel == SEL_W'(SEL_WIN0 + 2 * i))
                rd_data = {base_q[i], attr_q[i], 8'h00};
            if (rd_sel == SEL_W'(SEL_WIN0 + 2 * i + 1))
                rd_data = {mask_q[i], 16'h0000};
        end
    end
endmodule

// File: rtl/awd_match.sv
// awd_match: compares the upper address half against every window and
// returns one match bit per window. A set mask bit drops that address bit
// from the compare. Assumes the masks are already aligned to bits [31:16].
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  hi_t                     addr_hi,
    input  logic [NUM_WIN-1:0]      win_en,
    input  hi_t   [NUM_WIN-1:0]     base_q,
    input  hi_t   [NUM_WIN-1:0]     mask_q,
    output logic  [NUM_WIN-1:0]     match
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        // Masked equality compare for window i
        always_comb begin
            match[i] = win_en[i] && (((addr_hi ^ base_q[i]) & ~mask_q[i]) == '0);
        end
    end
endmodule

// File: rtl/awd_select.sv
// awd_select: picks the lowest-numbered matching window, forwards its
// attribute, and checks its access field against the lookup direction.
// Assumes one match bit per window; every output is zero on a miss.
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input  logic  [NUM_WIN-1:0]     match,
    input  attr_t [NUM_WIN-1:0]     attr_q,
    input  acc_t  [NUM_WIN-1:0]     acc,
    input  logic                    is_write,
    output logic                    hit,
    output logic  [IDX_W-1:0]       win,
    output attr_t                   attr,
    output logic                    prot_err
);
    acc_t sel_acc;

    // Priority encode: scan downward so the lowest index is assigned last
    always_comb begin
        hit     = 1'b0;
        win     = '0;
        attr    = '0;
        sel_acc = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                win     = IDX_W'(i);
                attr    = attr_q[i];
                sel_acc = acc[i];
            end
        end
    end

    // Permission check for the chosen window
    always_comb begin
        prot_err = hit && (is_write ? !sel_acc[ACC_WR] : !sel_acc[ACC_RD]);
    end
endmodule

// File: rtl/addr_window_decoder.sv
// addr_window_decoder: top level. Contains the register file and a
// combinational lookup path (masked match, then priority select, then
// permission check). Assumes 2 <= NUM_WIN <= 8 and a SEL_W wide enough
// for 2 + 2*NUM_WIN selects.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int SEL_W   = $clog2(SEL_WIN0 + 2 * NUM_WIN),
    parameter int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [31:0]         wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [31:0]         rd_data,
    input  logic [31:0]         lk_addr,
    input  logic                lk_write,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic [IDX_W-1:0]    lk_win,
    output logic [7:0]          lk_attr,
    output logic                lk_prot_err
);
    logic [31:0]          ctrl_q;
    logic [31:0]          ovrd_q;
    hi_t   [NUM_WIN-1:0]  base_q;
    attr_t [NUM_WIN-1:0]  attr_q;
    hi_t   [NUM_WIN-1:0]  mask_q;
    logic  [NUM_WIN-1:0]  win_en;
    acc_t  [NUM_WIN-1:0]  acc;
    logic  [NUM_WIN-1:0]  match;

    awd_regfile #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .ovrd_q  (ovrd_q),
        .base_q  (base_q),
        .attr_q  (attr_q),
        .mask_q  (mask_q)
    );

    // Split the control word into enable bits and access fields
    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            win_en[i] = ctrl_q[i];
            acc[i]    = ctrl_q[ACC_LSB + 2 * i +: 2];
        end
    end

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr_hi (lk_addr[31:16]),
        .win_en  (win_en),
        .base_q  (base_q),
        .mask_q  (mask_q),
        .match   (match)
    );

    awd_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .match    (match),
        .attr_q   (attr_q),
        .acc      (acc),
        .is_write (lk_write),
        .hit      (lk_hit),
        .win      (lk_win),
        .attr     (lk_attr),
        .prot_err (lk_prot_err)
    );

    // Miss flag is the complement of the hit flag
    always_comb lk_miss = !lk_hit;

    logic unused_ovrd;
    always_comb unused_ovrd = ^ovrd_q;
endmodule

// File: rtl/awd_checker.sv
// awd_checker: protocol and output-consistency properties for
// addr_window_decoder, attached to it by a bind statement.
module awd_checker #(
    parameter int NUM_WIN = 5,
    parameter int SEL_W   = 4,
    parameter int IDX_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [31:0]       wr_data,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [31:0]       rd_data,
    input logic [31:0]       ctrl_q,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [IDX_W-1:0]  lk_win,
    input logic [7:0]        lk_attr,
    input logic              lk_prot_err
);
    localparam int NUM_REG = 2 + 2 * NUM_WIN;

    a_r1_reset_misses: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lk_miss);

    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (rd_sel != '0 || rd_data == $past(wr_data)));

    a_r3_hit_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({lk_hit, lk_miss}));

    a_r4_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[NUM_WIN-1:0] == '0) |-> lk_miss);

    a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_win == '0 && lk_attr == '0 && !lk_prot_err));

    a_r8_err_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prot_err |-> lk_hit);

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_REG) |-> rd_data == '0);
endmodule

bind addr_window_decoder awd_checker #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .ctrl_q      (ctrl_q),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_win      (lk_win),
    .lk_attr     (lk_attr),
    .lk_prot_err (lk_prot_err)
);

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
    localparam int NW    = 5;
    localparam int SW    = 4;
    localparam int IW    = 3;
    localparam int NREG  = 2 + 2 * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic [SW-1:0] rd_sel = '0;
    logic [31:0]   rd_data;
    logic [31:0]   lk_addr = '0;
    logic          lk_write = 1'b0;
    logic          lk_hit, lk_miss, lk_prot_err;
    logic [IW-1:0] lk_win;
    logic [7:0]    lk_attr;

    int total = 0;
    int bad = 0;

    // Model of the written register contents, built from the requirements
    logic [31:0] m_reg [NREG];

    always #2.5 clk = ~clk;

    addr_window_decoder #(.NUM_WIN(NW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .lk_addr(lk_addr), .lk_write(lk_write), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_win(lk_win), .lk_attr(lk_attr),
        .lk_prot_err(lk_prot_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Stored-value masking per R2
    function automatic logic [31:0] keep_mask(input int sel);
        if (sel < 2) return 32'hFFFF_FFFF;
        if (sel % 2 == 0) return 32'hFFFF_FF00;
        return 32'hFFFF_0000;
    endfunction

    task automatic write_reg(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SW'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel < NREG) m_reg[sel] = d & keep_mask(sel);
    endtask

    task automatic read_check(input int sel, input string req);
        logic [31:0] exp;
        exp = (sel < NREG) ? m_reg[sel] : 32'h0;
        rd_sel = SW'(sel);
        #1;
        check(rd_data == exp, req, 64'(rd_data), 64'(exp));
    endtask

    // Expected lookup per R3..R8: {hit, miss, win, attr, err}
    function automatic logic [13:0] expect_lk(input logic [31:0] a, input bit w);
        logic [15:0] b, m;
        logic [1:0]  acc;
        for (int i = 0; i < NW; i++) begin
            b = m_reg[2 + 2 * i][31:16];
            m = m_reg[3 + 2 * i][31:16];
            if (m_reg[0][i] && (((a[31:16] ^ b) & ~m) == 16'h0)) begin
                acc = m_reg[0][16 + 2 * i +: 2];
                return {1'b1, 1'b0, 3'(i), m_reg[2 + 2 * i][15:8], (w ? !acc[1] : !acc[0])};
            end
        end
        return {1'b0, 1'b1, 3'd0, 8'h00, 1'b0};
    endfunction

    task automatic lookup_check(input logic [31:0] a, input bit w, input string req);
        logic [13:0] exp, act;
        lk_addr = a; lk_write = w;
        #1;
        exp = expect_lk(a, w);
        act = {lk_hit, lk_miss, lk_win, lk_attr, lk_prot_err};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    task automatic sweep(input string req);
        logic [31:0] a;
        for (int k = 0; k < 128; k++) begin
            a = (32'(k) << 25) | ((32'(k) * 32'h0001_3579) & 32'h01FF_FFFF);
            lookup_check(a, 1'b0, req);
            lookup_check(a, 1'b1, req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 16; s++) read_check(s, "R1 reset readback");
        lookup_check(32'h0000_0000, 1'b0, "R1 reset lookup");
        lookup_check(32'h4000_0000, 1'b1, "R1 reset lookup");

        // R2 and R9: write and read back every register with a distinct pattern
        for (int s = 0; s < NREG; s++) write_reg(s, 32'h9E37_79B9 * 32'(s + 1));
        for (int s = 0; s < NREG; s++) read_check(s, "R2 readback masking");
        // R9: unmapped selects ignored on write, zero on read
        write_reg(13, 32'hFFFF_FFFF);
        write_reg(15, 32'h1234_5678);
        for (int s = 0; s < 16; s++) read_check(s, "R9 unmapped select");

        // DRAM windows at 256 MB steps, SRAM window at 0x4000_0000 of 64 MB
        write_reg(2, 32'h0000_0E00); write_reg(3, 32'h0FFF_0000);
        write_reg(4, 32'h1000_0D00); write_reg(5, 32'h0FFF_0000);
        write_reg(6, 32'h2000_0B00); write_reg(7, 32'h0FFF_0000);
        write_reg(8, 32'h3000_0700); write_reg(9, 32'h0FFF_0000);
        write_reg(10, 32'h4000_1E00); write_reg(11, 32'h03FF_0000);

        // R3 R7 R8: all enabled, mixed rights (rw, r, w, none, rw)
        write_reg(0, 32'h0000_0000 | (32'h3 << 16) | (32'h1 << 18) | (32'h2 << 20) | (32'h0 << 22) | (32'h3 << 24) | 32'h1F);
        sweep("R3 R7 R8 disjoint windows");
        lookup_check(32'h43FF_FFFF, 1'b0, "R3 64MB top edge");
        lookup_check(32'h4400_0000, 1'b0, "R3 64MB past edge");
        lookup_check(32'h0FFF_FFFF, 1'b1, "R3 256MB top edge");

        // R4: partial enable
        write_reg(0, 32'h00FF_0000 | 32'h1A);
        sweep("R4 partial enable");
        // R4 R6: nothing enabled
        write_reg(0, 32'hFFFF_0000);
        sweep("R4 R6 none enabled");
        // R8: all enabled, no rights
        write_reg(0, 32'h0000_001F);
        sweep("R8 no rights");

        // R5: overlapping DRAM windows at base 0, differing rights
        write_reg(2, 32'h0000_0E00);
        write_reg(4, 32'h0000_0D00);
        write_reg(6, 32'h0000_0B00);
        write_reg(8, 32'h0000_0700);
        for (int p = 0; p < 4; p++) begin
            write_reg(0, (32'h0123_0000 << (p * 2)) & 32'h03FF_0000 | (32'h1F >> p) | 32'h10);
            sweep("R5 overlap priority");
        end

        // R10: override word does not disturb lookups, and clears to zero
        write_reg(0, 32'h03FF_001F);
        write_reg(1, 32'hDEAD_BEEF);
        sweep("R10 override no effect");
        read_check(1, "R10 override readback");
        write_reg(1, 32'h0);
        read_check(1, "R10 override cleared");
        sweep("R10 override cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule